// File: doc/BRIEF.md
# PIPE Control Handshake Sequencer

This block runs on the MAC side of a PIPE PHY in the pclk domain. It takes control requests one at a time and drives the matching PHY control pins. Four kinds of request are supported: a signalling-rate change, a power-state change, a receiver-detection run, and a reconfiguration of the PHY mode and elastic-buffer mode. For each request the block waits for the PHY's one-cycle completion pulse. It then returns a response pulse that carries an error flag and, for detection, a receiver-present flag.

Requests enter on a valid/ready handshake. The requester raises `req_valid` with `req_op` and `req_arg` and must hold all three steady until a cycle in which `req_ready` is also high. The request is taken at that clock edge. `req_ready` stays low while an operation is outstanding, so a held request simply waits. Responses appear on `rsp_valid`, a plain one-cycle pulse with no back-pressure. `rsp_err` and `rsp_present` are registered with it and hold their values until the next response.

A reconfiguration has no PHY handshake. Instead the block holds the active-high PHY reset for a fixed number of cycles. A programmable timeout ends any handshake that gets no completion pulse and reports it as an error. The transmit de-emphasis select is filtered so that the reserved code can never reach the PHY.

Top module: `pipe_ctrl_seq`

## Requirements
- R1: At most one operation is outstanding. `req_ready` is high only when the block is idle, and it falls in the cycle after a request is accepted. At completion, `rsp_valid` is high for exactly one cycle, and `req_ready` rises in that same cycle.
- R2: Op code 0 (rate) drives `phy_rate` to `req_arg[0]` from the cycle after acceptance (0 = 2.5 GT/s, 1 = 5 GT/s). The operation completes on a `phy_status` pulse with `rsp_err` = 0.
- R3: Op code 1 (power) drives `phy_pwr` to `req_arg[1:0]` from the cycle after acceptance. The operation completes on a `phy_status` pulse.
- R4: Op code 2 (detect) raises `phy_detrx` from the cycle after acceptance. `phy_detrx` falls in the cycle after the completion pulse, or after a timeout.
- R5: When a detect completes, `rsp_present` is 1 exactly when `rx_status` equals 3'b011 in the cycle of the completion pulse. Every other response carries `rsp_present` = 0.
- R6: Op code 3 (reconfigure) sets `phy_mode` to `req_arg[1:0]` (0 = PCI Express, 1 = SuperSpeed USB) and `phy_ebmode` to `req_arg[2]` (0 = half-full, 1 = empty). It also holds `phy_rst` high for exactly RST_CYCLES cycles, starting the cycle after acceptance. A response with `rsp_err` = 0 follows in the cycle after `phy_rst` falls.
- R7: If no `phy_status` pulse arrives within `cfg_timeout` cycles of acceptance (a value of 0 counts as 1), the block gives up. It returns a response with `rsp_err` = 1 and `rsp_present` = 0.
- R8: `tx_deemph` follows `deemph_sel` one cycle later (0 = -6 dB, 1 = -3.5 dB, 2 = 0 dB). A select of 3 is ignored and the previous value is kept, so `tx_deemph` is never 3.
- R9: A `phy_status` pulse while idle or during the reset hold produces no response and changes no output.
- R10: During reset the outputs take these values: `req_ready` 1, `rsp_valid`/`rsp_err`/`rsp_present` 0, `phy_rate` 0, `phy_pwr` PWR_INIT (2), `phy_detrx` 0, `phy_mode` 1, `phy_ebmode` 0, `phy_rst` 0, `tx_deemph` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | PIPE interface clock |
| rst_n | input | 1 | Active-low asynchronous block reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_op | input | 2 | 0 rate, 1 power, 2 detect, 3 reconfigure |
| req_arg | input | 3 | Operation argument |
| cfg_timeout | input | TMO_W | Completion timeout in cycles |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Last operation timed out |
| rsp_present | output | 1 | Last detect found a receiver |
| deemph_sel | input | 2 | Requested de-emphasis code |
| phy_status | input | 1 | PHY completion pulse |
| rx_status | input | 3 | PHY receive status code |
| phy_rate | output | 1 | Rate select to PHY |
| phy_pwr | output | 2 | Power state to PHY |
| phy_detrx | output | 1 | Detect / loopback control to PHY |
| phy_mode | output | 2 | Protocol mode to PHY |
| phy_ebmode | output | 1 | Elastic buffer mode to PHY |
| phy_rst | output | 1 | Active-high PHY reset |
| tx_deemph | output | 2 | De-emphasis code to PHY |

## Verification
The bench aims at these cases:
- A request held asserted while another operation is busy. A design that accepted it early would overwrite a PHY control mid-handshake.
- Completion pulses that land in the very first wait cycle and in the last allowed cycle before the timeout. An off-by-one timeout counter either drops a legal completion or lets an operation overrun.
- Stray `phy_status` pulses while idle and during the reset hold. A design that listened to them would emit spurious responses or cut the reset short.
- Detection with a present code and an absent code, and the reserved de-emphasis code. These expose a wrong result decode and a leaked reserved code.

// File: rtl/pipe_seq_pkg.sv
package pipe_seq_pkg;
  typedef enum logic [1:0] {
    OP_RATE   = 2'd0,
    OP_POWER  = 2'd1,
    OP_DETECT = 2'd2,
    OP_RECONF = 2'd3
  } seq_op_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WAIT = 2'd1,
    S_RST  = 2'd2
  } seq_state_e;

  localparam logic [2:0] RX_RCVR_FOUND = 3'b011;
  localparam logic [1:0] DEEMPH_RSVD   = 2'd3;
endpackage

// File: rtl/pipe_seq_timer.sv
module pipe_seq_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (cnt != '1)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pipe_seq_deemph.sv
module pipe_seq_deemph
  import pipe_seq_pkg::*;
#(
  parameter logic [1:0] DE_INIT = 2'd1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  output logic [1:0] de
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  de <= DE_INIT;
    else if (sel != DEEMPH_RSVD) de <= sel;
  end
endmodule

// File: rtl/pipe_seq_fsm.sv
module pipe_seq_fsm
  import pipe_seq_pkg::*;
#(
  parameter int         TMO_W      = 16,
  parameter int         RST_CYCLES = 4,
  parameter int         CNT_W      = 16,
  parameter logic [1:0] PWR_INIT   = 2'd2,
  parameter logic [1:0] MODE_INIT  = 2'd1,
  parameter logic       EB_INIT    = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [2:0]       req_arg,
  input  logic [TMO_W-1:0] cfg_timeout,
  input  logic             phy_status,
  input  logic [2:0]       rx_status,
  input  logic [CNT_W-1:0] cnt,
  output logic             cnt_clr,
  output logic             req_ready,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic             rsp_present,
  output logic             phy_rate,
  output logic [1:0]       phy_pwr,
  output logic             phy_detrx,
  output logic [1:0]       phy_mode,
  output logic             phy_ebmode,
  output logic             phy_rst
);
  localparam int CW1 = CNT_W + 1;

  seq_state_e      state;
  seq_op_e         op_q;
  logic [CNT_W:0]  cnt_nxt;
  logic            tmo_hit;
  logic            rst_done;

  assign cnt_nxt   = {1'b0, cnt} + 1'b1;
  assign tmo_hit   = cnt_nxt >= CW1'(cfg_timeout);
  assign rst_done  = cnt_nxt >= CW1'(RST_CYCLES);
  assign cnt_clr   = (state == S_IDLE);
  assign req_ready = (state == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      op_q        <= OP_RATE;
      rsp_valid   <= 1'b0;
      rsp_err     <= 1'b0;
      rsp_present <= 1'b0;
      phy_rate    <= 1'b0;
      phy_pwr     <= PWR_INIT;
      phy_detrx   <= 1'b0;
      phy_mode    <= MODE_INIT;
      phy_ebmode  <= EB_INIT;
      phy_rst     <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (req_valid) begin
            op_q <= seq_op_e'(req_op);
            unique case (seq_op_e'(req_op))
              OP_RATE: begin
                phy_rate <= req_arg[0];
                state    <= S_WAIT;
              end
              OP_POWER: begin
                phy_pwr <= req_arg[1:0];
                state   <= S_WAIT;
              end
              OP_DETECT: begin
                phy_detrx <= 1'b1;
                state     <= S_WAIT;
              end
              OP_RECONF: begin
                phy_mode   <= req_arg[1:0];
                phy_ebmode <= req_arg[2];
                phy_rst    <= 1'b1;
                state      <= S_RST;
              end
              default: state <= S_IDLE;
            endcase
          end
        end
        S_WAIT: begin
          if (phy_status) begin
            rsp_valid   <= 1'b1;
            rsp_err     <= 1'b0;
            rsp_present <= (op_q == OP_DETECT) && (rx_status == RX_RCVR_FOUND);
            phy_detrx   <= 1'b0;
            state       <= S_IDLE;
          end else if (tmo_hit) begin
            rsp_valid   <= 1'b1;
            rsp_err     <= 1'b1;
            rsp_present <= 1'b0;
            phy_detrx   <= 1'b0;
            state       <= S_IDLE;
          end
        end
        S_RST: begin
          if (rst_done) begin
            phy_rst     <= 1'b0;
            rsp_valid   <= 1'b1;
            rsp_err     <= 1'b0;
            rsp_present <= 1'b0;
            state       <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pipe_ctrl_seq.sv
module pipe_ctrl_seq
  import pipe_seq_pkg::*;
#(
  parameter int         TMO_W      = 16,
  parameter int         RST_CYCLES = 4,
  parameter logic [1:0] PWR_INIT   = 2'd2,
  parameter logic [1:0] MODE_INIT  = 2'd1,
  parameter logic       EB_INIT    = 1'b0,
  parameter logic [1:0] DE_INIT    = 2'd1
) (
  input  logic             pclk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [2:0]       req_arg,
  input  logic [TMO_W-1:0] cfg_timeout,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic             rsp_present,
  input  logic [1:0]       deemph_sel,
  input  logic             phy_status,
  input  logic [2:0]       rx_status,
  output logic             phy_rate,
  output logic [1:0]       phy_pwr,
  output logic             phy_detrx,
  output logic [1:0]       phy_mode,
  output logic             phy_ebmode,
  output logic             phy_rst,
  output logic [1:0]       tx_deemph
);
  localparam int RST_W = $clog2(RST_CYCLES + 1);
  localparam int CNT_W = (TMO_W > RST_W) ? TMO_W : RST_W;

  logic [CNT_W-1:0] cnt;
  logic             cnt_clr;

  pipe_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(pclk), .rst_n(rst_n), .clr(cnt_clr), .cnt(cnt)
  );

  pipe_seq_fsm #(
    .TMO_W(TMO_W), .RST_CYCLES(RST_CYCLES), .CNT_W(CNT_W),
    .PWR_INIT(PWR_INIT), .MODE_INIT(MODE_INIT), .EB_INIT(EB_INIT)
  ) u_fsm (
    .clk(pclk), .rst_n(rst_n),
    .req_valid(req_valid), .req_op(req_op), .req_arg(req_arg),
    .cfg_timeout(cfg_timeout), .phy_status(phy_status), .rx_status(rx_status),
    .cnt(cnt), .cnt_clr(cnt_clr), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_present(rsp_present),
    .phy_rate(phy_rate), .phy_pwr(phy_pwr), .phy_detrx(phy_detrx),
    .phy_mode(phy_mode), .phy_ebmode(phy_ebmode), .phy_rst(phy_rst)
  );

  pipe_seq_deemph #(.DE_INIT(DE_INIT)) u_deemph (
    .clk(pclk), .rst_n(rst_n), .sel(deemph_sel), .de(tx_deemph)
  );
endmodule

// File: rtl/pipe_seq_chk.sv
module pipe_seq_chk (
  input logic       pclk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       rsp_err,
  input logic       rsp_present,
  input logic       phy_status,
  input logic       phy_rate,
  input logic [1:0] phy_pwr,
  input logic       phy_detrx,
  input logic       phy_rst,
  input logic [1:0] tx_deemph
);
  // R1
  accept_then_busy_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R1
  rsp_single_pulse_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R1
  rsp_frees_ready_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    rsp_valid |-> req_ready);
  // R2
  rate_held_busy_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(phy_rate));
  // R3
  pwr_held_busy_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(phy_pwr));
  // R4
  detrx_drop_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    (phy_detrx && phy_status && !req_ready) |=> !phy_detrx);
  // R5
  present_only_ok_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    rsp_present |-> !rsp_err);
  // R6
  rst_blocks_ready_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    phy_rst |-> !req_ready);
  // R8
  deemph_legal_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    tx_deemph != 2'd3);
  // R9
  idle_status_quiet_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> !rsp_valid);
endmodule

bind pipe_ctrl_seq pipe_seq_chk u_chk (
  .pclk(pclk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_present(rsp_present),
  .phy_status(phy_status), .phy_rate(phy_rate), .phy_pwr(phy_pwr),
  .phy_detrx(phy_detrx), .phy_rst(phy_rst), .tx_deemph(tx_deemph)
);

// File: tb/tb_pipe_ctrl_seq.sv
module tb_pipe_ctrl_seq;
  localparam int TMO_W = 16;
  localparam int RSTC  = 4;

  logic pclk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_op = '0;
  logic [2:0] req_arg = '0;
  logic [TMO_W-1:0] cfg_timeout = 16'd8;
  logic rsp_valid, rsp_err, rsp_present;
  logic [1:0] deemph_sel = 2'd1;
  logic phy_status = 1'b0;
  logic [2:0] rx_status = '0;
  logic phy_rate, phy_detrx, phy_ebmode, phy_rst;
  logic [1:0] phy_pwr, phy_mode, tx_deemph;

  always #10 pclk = ~pclk;

  pipe_ctrl_seq #(.TMO_W(TMO_W), .RST_CYCLES(RSTC)) dut (
    .pclk(pclk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_arg(req_arg), .cfg_timeout(cfg_timeout),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_present(rsp_present),
    .deemph_sel(deemph_sel), .phy_status(phy_status), .rx_status(rx_status),
    .phy_rate(phy_rate), .phy_pwr(phy_pwr), .phy_detrx(phy_detrx),
    .phy_mode(phy_mode), .phy_ebmode(phy_ebmode), .phy_rst(phy_rst),
    .tx_deemph(tx_deemph)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  // behavioural reference: phase 0 idle, 1 handshake, 2 reset hold
  int phase = 0, waited = 0, cur_op = 0;
  int m_ready = 1, m_rv = 0, m_err = 0, m_pres = 0, m_rate = 0, m_pwr = 2;
  int m_det = 0, m_mode = 1, m_eb = 0, m_rst = 0, m_de = 1;

  always @(posedge pclk) begin
    if (!rst_n) begin
      phase = 0; m_rv = 0; m_err = 0; m_pres = 0; m_rate = 0; m_pwr = 2;
      m_det = 0; m_mode = 1; m_eb = 0; m_rst = 0; m_de = 1;
    end else begin
      int lim;
      lim = (cfg_timeout == 0) ? 1 : int'(cfg_timeout);
      if (deemph_sel != 2'd3) m_de = deemph_sel;
      m_rv = 0;
      if (phase == 0) begin
        if (req_valid) begin
          cur_op = req_op; waited = 0;
          if (req_op == 0) begin m_rate = req_arg[0]; phase = 1; end
          else if (req_op == 1) begin m_pwr = req_arg[1:0]; phase = 1; end
          else if (req_op == 2) begin m_det = 1; phase = 1; end
          else begin m_mode = req_arg[1:0]; m_eb = req_arg[2]; m_rst = 1; phase = 2; end
        end
      end else if (phase == 1) begin
        waited++;
        if (phy_status) begin
          m_rv = 1; m_err = 0; m_det = 0; phase = 0;
          m_pres = (cur_op == 2 && rx_status == 3'b011) ? 1 : 0;
        end else if (waited >= lim) begin
          m_rv = 1; m_err = 1; m_pres = 0; m_det = 0; phase = 0;
        end
      end else begin
        waited++;
        if (waited >= RSTC) begin
          m_rst = 0; m_rv = 1; m_err = 0; m_pres = 0; phase = 0;
        end
      end
    end
    m_ready = (phase == 0) ? 1 : 0;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  task automatic cmp_all();
    chk("R1 req_ready", req_ready, m_ready);
    chk("R1 rsp_valid", rsp_valid, m_rv);
    chk("R7 rsp_err", rsp_err, m_err);
    chk("R5 rsp_present", rsp_present, m_pres);
    chk("R2 phy_rate", phy_rate, m_rate);
    chk("R3 phy_pwr", phy_pwr, m_pwr);
    chk("R4 phy_detrx", phy_detrx, m_det);
    chk("R6 phy_mode", phy_mode, m_mode);
    chk("R6 phy_ebmode", phy_ebmode, m_eb);
    chk("R6 phy_rst", phy_rst, m_rst);
    chk("R8 tx_deemph", tx_deemph, m_de);
  endtask

  task automatic step();
    @(negedge pclk);
    cmp_all();
  endtask

  task automatic issue(input int op, input int arg);
    req_valid = 1'b1; req_op = 2'(op); req_arg = 3'(arg);
    do step(); while (m_ready == 0 && phase == 0);
    req_valid = 1'b0;
  endtask

  task automatic pulse_status(input int dly, input int rxs);
    for (int i = 0; i < dly; i++) step();
    phy_status = 1'b1; rx_status = 3'(rxs);
    step();
    phy_status = 1'b0; rx_status = 3'd0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  always @(posedge pclk) begin
    cycles++;
    if (cycles > 20000) begin
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int rst_hi;
    @(negedge pclk);
    // R10 reset state
    chk("R10 ready", req_ready, 1);
    chk("R10 pwr", phy_pwr, 2);
    chk("R10 mode", phy_mode, 1);
    chk("R10 rst", phy_rst, 0);
    chk("R10 deemph", tx_deemph, 1);
    step(); step();
    rst_n = 1'b1;
    idle(2);

    // R2 rate change, completion two cycles after accept
    issue(0, 1);
    chk("R2 rate driven", phy_rate, 1);
    pulse_status(1, 0);
    idle(1);

    // R3 power change, completion in the first wait cycle
    issue(1, 3);
    chk("R3 pwr driven", phy_pwr, 3);
    pulse_status(0, 0);
    idle(1);

    // R4/R5 detect, receiver present
    issue(2, 0);
    chk("R4 detrx high", phy_detrx, 1);
    pulse_status(2, 3);
    chk("R4 detrx low", phy_detrx, 0);
    chk("R5 present", rsp_present, 1);
    idle(1);

    // R5 detect, other code
    issue(2, 0);
    pulse_status(1, 2);
    chk("R5 absent", rsp_present, 0);
    idle(1);

    // R1 request held while busy
    issue(0, 0);
    req_valid = 1'b1; req_op = 2'd1; req_arg = 3'd0;
    idle(3);
    chk("R1 held off", phy_pwr, 3);
    pulse_status(0, 0);
    idle(2);
    req_valid = 1'b0;
    chk("R1 taken after", phy_pwr, 0);
    pulse_status(1, 0);
    idle(1);

    // R7 timeout, completion in last allowed cycle first
    cfg_timeout = 16'd5;
    issue(0, 1);
    pulse_status(4, 0);
    chk("R7 last cycle ok", rsp_err, 0);
    idle(1);
    issue(2, 0);
    idle(6);
    chk("R7 timed out", rsp_err, 1);
    chk("R4 detrx after timeout", phy_detrx, 0);
    pulse_status(0, 3);
    chk("R9 late status", rsp_present, 0);
    cfg_timeout = 16'd0;
    issue(1, 1);
    idle(2);
    chk("R7 zero timeout", rsp_err, 1);
    cfg_timeout = 16'd8;

    // R6 reconfigure with stray status during hold (R9)
    issue(3, 5);
    rst_hi = 1;
    phy_status = 1'b1; step(); phy_status = 1'b0;
    if (phy_rst) rst_hi++;
    for (int i = 0; i < 5; i++) begin
      step();
      if (phy_rst) rst_hi++;
    end
    chk("R6 rst width", rst_hi, RSTC);
    chk("R6 mode", phy_mode, 1);
    chk("R6 ebmode", phy_ebmode, 1);
    idle(1);

    // R8 de-emphasis filtering
    deemph_sel = 2'd0; idle(2);
    chk("R8 sel0", tx_deemph, 0);
    deemph_sel = 2'd3; idle(2);
    chk("R8 rsvd ignored", tx_deemph, 0);
    deemph_sel = 2'd2; idle(2);
    chk("R8 sel2", tx_deemph, 2);

    // R9 stray status while idle
    pulse_status(0, 3);
    idle(1);
    chk("R9 idle no rsp", rsp_valid, 0);
    idle(3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule